// File: doc/BRIEF.md
# Per-Field Calendar Alarm Comparator

This block holds a set of calendar alarm values and tests them against the running calendar once per second. Time keeping happens elsewhere. The block receives the current seconds, minutes, hours, day of month, month and year as BCD inputs, together with a single-cycle pulse that marks each one-second advance. On that pulse it compares every field whose enable bit is set with the stored alarm value for that field. A master enable gates the whole comparison.

When any enabled field matches while the master enable is set, a pending flag is latched and the alarm interrupt goes high. Software clears the flag by writing 1 to it. The six alarm values, the control register and the pending flag sit behind a small word-addressed register port. Writes take effect on the next clock edge. Reads are combinational.

Top module: `calendar_alarm`

## Requirements
- R1: The control register at address 0 holds one enable bit per field: bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day of month, bit 4 month, bit 5 year. A field whose enable bit is clear never causes a fire.
- R2: Control bit 6 is the master enable. While it is clear, no second pulse sets the pending flag, whatever the field enables and values are.
- R3: The alarm values sit at addresses 1 to 6, in the order seconds, minutes, hours, day, month, year. A write stores the value masked to 7, 7, 6, 6, 5 and 12 bits respectively, and a read returns the masked value zero-extended to 12 bits.
- R4: Each comparison is an exact equality between the stored value and the BCD input for that field. The year compares all 12 bits, which is three BCD digits. A binary encoding of the same number does not match.
- R5: The comparison happens only in a cycle where `sec_pulse_i` is high. A matching calendar without a pulse does not fire. A fire becomes visible on `alarm_irq_o` after the clock edge that samples the pulse.
- R6: A fire occurs when at least one enabled field matches. The other enabled fields need not match.
- R7: A fire sets the pending flag. It reads as bit 1 at address 7, with bit 0 reading 0. `alarm_irq_o` equals the pending flag.
- R8: Writing to address 7 with bit 1 set clears the pending flag and lowers the interrupt. Writing with bit 1 clear leaves the flag unchanged. If a fire and a clear occur in the same cycle, the fire wins.
- R9: The active-low asynchronous reset clears the control register, all six alarm values and the pending flag.
- R10: The control register keeps only bits 6:0 of a write, and a read returns them zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_pulse_i | input | 1 | One-cycle pulse after each second advance |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| cur_day_i | input | 8 | Current day of month, BCD |
| cur_mon_i | input | 8 | Current month, BCD |
| cur_year_i | input | 12 | Current year, three BCD digits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address, used for both read and write |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data, combinational |
| alarm_irq_o | output | 1 | Alarm interrupt, level, equal to the pending flag |

## Verification
A corrupted stored alarm value or control bit does not show up on the interrupt until the next second pulse meets a calendar that should or should not match. It does show up at once on a read of that address. For this reason the bench reads back every register it writes. A wrong pending flag is visible on `alarm_irq_o` in the cycle after the faulty edge, and on a read of address 7. The bench targets the cases where the interrupt is the only symptom: a disabled master, a disabled field, a binary-coded field, a year mismatch in the hundreds digit, and a clear that collides with a fire.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DATA_W     = 12;
  localparam int ADDR_W     = 3;
  localparam int CTRL_W     = NUM_FIELDS + 1;
  localparam int MASTER_BIT = NUM_FIELDS;
  localparam int PEND_BIT   = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 3'd0,
    ADDR_SEC  = 3'd1,
    ADDR_MIN  = 3'd2,
    ADDR_HOUR = 3'd3,
    ADDR_DAY  = 3'd4,
    ADDR_MON  = 3'd5,
    ADDR_YEAR = 3'd6,
    ADDR_PEND = 3'd7
  } reg_addr_e;

  // stored width of each alarm field, index 0 = seconds
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import cal_alarm_pkg::*;
#(
  parameter int N_FIELD = NUM_FIELDS,
  parameter int DW      = DATA_W,
  parameter int AW      = ADDR_W,
  localparam int CW     = N_FIELD + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     pend_i,
  output logic [DW-1:0]            rdata_o,
  output logic [CW-1:0]            ctrl_o,
  output logic [N_FIELD-1:0][DW-1:0] alm_o
);
  logic [CW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        ctrl_q <= '0;
    else if (we_i && addr_i == AW'(ADDR_CTRL))          ctrl_q <= wdata_i[CW-1:0];
  end

  for (genvar f = 0; f < N_FIELD; f++) begin : g_field
    localparam int FW = field_width(f);
    localparam logic [DW-1:0] MASK = DW'((64'd1 << FW) - 64'd1);
    logic [DW-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      val_q <= '0;
      else if (we_i && addr_i == AW'(f + 1))            val_q <= wdata_i & MASK;
    end
    assign alm_o[f] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL))      rdata_o = DW'(ctrl_q);
    else if (addr_i == AW'(ADDR_PEND)) rdata_o[PEND_BIT] = pend_i;
    else begin
      for (int f = 0; f < N_FIELD; f++)
        if (addr_i == AW'(f + 1)) rdata_o = alm_o[f];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int DW = 12
) (
  input  logic          en_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] alm_i,
  output logic          match_o
);
  assign match_o = en_i && (cur_i == alm_i);
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  // fire has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (fire_i) pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end
  assign pend_o = pend_q;
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
  import cal_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_pulse_i,
  input  logic [7:0]        cur_sec_i,
  input  logic [7:0]        cur_min_i,
  input  logic [7:0]        cur_hour_i,
  input  logic [7:0]        cur_day_i,
  input  logic [7:0]        cur_mon_i,
  input  logic [11:0]       cur_year_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              alarm_irq_o
);
  logic [CTRL_W-1:0]                   ctrl_q;
  logic [NUM_FIELDS-1:0][DATA_W-1:0]   alm_val;
  logic [NUM_FIELDS-1:0][DATA_W-1:0]   cur_val;
  logic [NUM_FIELDS-1:0]               match;
  logic                                pend;
  logic                                fire;
  logic                                clr;

  assign cur_val[0] = DATA_W'(cur_sec_i);
  assign cur_val[1] = DATA_W'(cur_min_i);
  assign cur_val[2] = DATA_W'(cur_hour_i);
  assign cur_val[3] = DATA_W'(cur_day_i);
  assign cur_val[4] = DATA_W'(cur_mon_i);
  assign cur_val[5] = DATA_W'(cur_year_i);

  alarm_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pend_i  (pend),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl_q),
    .alm_o   (alm_val)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    alarm_field_match #(.DW(DATA_W)) u_cmp (
      .en_i    (ctrl_q[f]),
      .cur_i   (cur_val[f]),
      .alm_i   (alm_val[f]),
      .match_o (match[f])
    );
  end

  assign fire = sec_pulse_i && ctrl_q[MASTER_BIT] && (|match);
  assign clr  = reg_we_i && (reg_addr_i == ADDR_PEND) && reg_wdata_i[PEND_BIT];

  alarm_pending u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign alarm_irq_o = pend;
endmodule

// File: rtl/calendar_alarm_chk.sv
module calendar_alarm_chk
  import cal_alarm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sec_pulse_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              clr_bit_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              alarm_irq_o,
  input logic              master_en_i
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == ADDR_PEND) && clr_bit_i;

  // R5
  irq_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_irq_o) |-> $past(sec_pulse_i));

  // R2
  master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_i && !master_en_i && !alarm_irq_o) |=> !alarm_irq_o);

  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !sec_pulse_i) |=> !alarm_irq_o);

  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_pulse_i && !clr_wr) |=> $stable(alarm_irq_o));

  // R3
  sec_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_SEC) |-> (reg_rdata_o[DATA_W-1:7] == '0));

  // R7
  pend_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_PEND) |-> (reg_rdata_o == DATA_W'({alarm_irq_o, 1'b0})));
endmodule

bind calendar_alarm calendar_alarm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_pulse_i (sec_pulse_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .clr_bit_i   (reg_wdata_i[1]),
  .reg_rdata_o (reg_rdata_o),
  .alarm_irq_o (alarm_irq_o),
  .master_en_i (ctrl_q[6])
);

// File: tb/test_calendar_alarm.sv
`timescale 1ns/1ps
module test_calendar_alarm;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        sec_pulse_i = 0;
  logic [7:0]  cur_sec_i = 0, cur_min_i = 0, cur_hour_i = 0, cur_day_i = 0, cur_mon_i = 0;
  logic [11:0] cur_year_i = 0;
  logic        reg_we_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [11:0] reg_wdata_i = 0;
  logic [11:0] reg_rdata_o;
  logic        alarm_irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { logic [11:0] data; logic irq; string tag; } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  always #2.5 clk_i = ~clk_i;

  calendar_alarm i_calendar_alarm (.*);

  // monitor
  initial forever begin
    exp_t e;
    @(sample_ev);
    e = sb_q.pop_front();
    n_chk++;
    if (reg_rdata_o !== e.data || alarm_irq_o !== e.irq) begin
      n_err++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               e.tag, reg_rdata_o, alarm_irq_o, e.data, e.irq);
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [11:0] d, input logic irq, input string tag);
    exp_t e;
    @(negedge clk_i);
    reg_addr_i = a;
    e.data = d; e.irq = irq; e.tag = tag;
    sb_q.push_back(e);
    #1 -> sample_ev;
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d, input bit pulse = 0);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; sec_pulse_i = pulse;
    @(negedge clk_i);
    reg_we_i = 0; sec_pulse_i = 0;
  endtask

  task automatic pulse();
    @(negedge clk_i);
    sec_pulse_i = 1;
    @(negedge clk_i);
    sec_pulse_i = 0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R9 reset state
    expect_rd(0, 12'h000, 0, "R9 ctrl");
    expect_rd(1, 12'h000, 0, "R9 sec");
    expect_rd(6, 12'h000, 0, "R9 year");
    expect_rd(7, 12'h000, 0, "R9 pend");
    // R3 / R10 masking
    for (int a = 0; a <= 6; a++) wr(3'(a), 12'hFFF);
    expect_rd(0, 12'h07F, 0, "R10 ctrl mask");
    expect_rd(1, 12'h07F, 0, "R3 sec mask");
    expect_rd(2, 12'h07F, 0, "R3 min mask");
    expect_rd(3, 12'h03F, 0, "R3 hour mask");
    expect_rd(4, 12'h03F, 0, "R3 day mask");
    expect_rd(5, 12'h01F, 0, "R3 mon mask");
    expect_rd(6, 12'hFFF, 0, "R3 year mask");
    // R2 master off
    wr(0, 12'h001); wr(1, 12'h045);
    cur_sec_i = 8'h45;
    pulse();
    expect_rd(7, 12'h000, 0, "R2 master off");
    // R5 no pulse -> no fire
    wr(0, 12'h041);
    repeat (4) @(negedge clk_i);
    expect_rd(7, 12'h000, 0, "R5 no pulse");
    pulse();
    expect_rd(7, 12'h002, 1, "R5 R7 fire on pulse");
    // R8 write bit0 only does nothing, bit1 clears
    wr(7, 12'h001);
    expect_rd(7, 12'h002, 1, "R8 bit0 no clear");
    wr(7, 12'h002);
    expect_rd(7, 12'h000, 0, "R8 w1c");
    // R1 no field enables
    wr(0, 12'h040);
    pulse();
    expect_rd(7, 12'h000, 0, "R1 no enables");
    // R1 min enabled only, sec matches but min not
    wr(2, 12'h030); cur_min_i = 8'h29;
    wr(0, 12'h042);
    pulse();
    expect_rd(7, 12'h000, 0, "R1 disabled field match ignored");
    // R6 any enabled field: sec and min enabled, only sec matches
    wr(0, 12'h043);
    pulse();
    expect_rd(7, 12'h002, 1, "R6 any match");
    wr(7, 12'h002);
    // R4 hour BCD vs binary
    wr(3, 12'h012); cur_hour_i = 8'h0C;
    wr(0, 12'h044);
    pulse();
    expect_rd(7, 12'h000, 0, "R4 binary hour no match");
    cur_hour_i = 8'h12;
    pulse();
    expect_rd(7, 12'h002, 1, "R4 bcd hour match");
    wr(7, 12'h002);
    // R4 year three digits
    wr(6, 12'h123); cur_year_i = 12'h023;
    wr(0, 12'h060);
    pulse();
    expect_rd(7, 12'h000, 0, "R4 year hundreds differ");
    cur_year_i = 12'h123;
    pulse();
    expect_rd(7, 12'h002, 1, "R4 year match");
    wr(7, 12'h002);
    // R1 day and month fields
    wr(4, 12'h031); wr(5, 12'h012); cur_day_i = 8'h31; cur_mon_i = 8'h11;
    wr(0, 12'h050);
    pulse();
    expect_rd(7, 12'h000, 0, "R1 month mismatch");
    wr(0, 12'h048);
    pulse();
    expect_rd(7, 12'h002, 1, "R1 day match");
    // R8 clear collides with fire: fire wins
    wr(7, 12'h002, 1);
    expect_rd(7, 12'h002, 1, "R8 fire beats clear");
    wr(7, 12'h002);
    expect_rd(7, 12'h000, 0, "R8 clear after collision");
    // R9 reset mid-run
    pulse();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    expect_rd(7, 12'h000, 0, "R9 pend after reset");
    expect_rd(0, 12'h000, 0, "R9 ctrl after reset");
    expect_rd(4, 12'h000, 0, "R9 day after reset");
    @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule